// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor

This block is a 32-bit processor core that retires exactly one instruction on every rising clock edge. It implements unsigned add, unsigned subtract, OR with an immediate, word load, word store and branch-on-equal. Inside are the program counter, a 32-entry by 32-bit register file, an arithmetic unit that adds, subtracts or ORs and raises a zero flag, an immediate widener, and two private word arrays: one holds the program, the other holds data.

Programs are written into the instruction array through a dedicated write port while reset is held low. After reset is released, execution starts at address 0. Results are observed through a combinational port that reads any architectural register by number.

Top module: `cpu_core`

## Requirements
- R1: While reset is low, the program counter is 0 and every register reads 0 on the debug port. After release, the first instruction executed is word 0.
- R2: Opcode 0x00 is the register format: source A in bits [25:21], source B in bits [20:16], destination in bits [15:11], function code in bits [5:0]. Function 0x21 writes A+B and function 0x23 writes A-B to the destination. Both results wrap modulo 2^32.
- R3: Opcode 0x0D writes register[25:21] OR the 16-bit immediate in bits [15:0], extended with zeros, into register [20:16].
- R4: Opcode 0x23 loads into register [20:16] the data word at byte address register[25:21] + sign-extended immediate. Opcode 0x2B stores register [20:16] to that same address. Data words are selected by byte-address bits [n+1:2].
- R5: Opcode 0x04 compares registers [25:21] and [20:16] through the subtract unit's zero flag. If they are equal, the next PC is PC+4+(sign-extended immediate times 4); otherwise it is PC+4. A branch writes neither a register nor memory.
- R6: Register 0 always reads 0, and writes aimed at it are discarded.
- R7: Any other opcode, or opcode 0x00 with any other function code, changes no register and no memory and only advances the PC by 4.
- R8: The debug port returns the selected register combinationally, including values written by the instruction on the previous edge.
- R9: Every instruction completes in a single cycle: a value written by one instruction is a valid source for the very next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Write enable for the instruction array |
| prog_idx | input | IAW | Word index in the instruction array to write |
| prog_word | input | 32 | Instruction word to store |
| peek_sel | input | 5 | Register number to observe |
| peek_val | output | 32 | Current contents of the selected register |

## Verification
The assertions assume three things. The program array is written only while reset is low. Programs never leave the instruction array. Every load or store address falls inside the data array and is word aligned. The stimulus keeps to these by writing each program during reset, using only small offsets that stay in range, and ending every program in a branch that loops to itself, so the PC stays on known words however long the run lasts. Results are checked only after that self-loop has been reached, so the expected register contents do not depend on exact cycle counts.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RSEL = $clog2(NREG);

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h21;
  localparam logic [5:0] FN_SUB   = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    imm_signed;
    alu_op_e alu_op;
    logic    dm_we;
    logic    wb_from_mem;
    logic    is_branch;
    logic    unknown;
  } ctl_t;

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] ra,
  input  logic [SW-1:0] rb,
  input  logic [SW-1:0] rc,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb,
  output logic [W-1:0]  qc
);

  logic [W-1:0] regs [N];

  assign regs[0] = '0;

  for (genvar g = 1; g < N; g++) begin : g_reg
    logic         en;
    logic [W-1:0] d;
    assign en = we && (waddr == SW'(g));
    always_comb d = en ? wdata : regs[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= '0;
      else        regs[g] <= d;
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];
  assign qc = regs[rc];

  // R6: register 0 observed through any port is zero
  a_r6_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (rc == '0) |-> (qc == '0));

  // R8/R9: a write to a nonzero register is visible on the next cycle
  a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0 && rc == waddr) ##1 (rc == $past(waddr)) |->
      (qc == $past(wdata)));

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '{rf_we: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0, imm_signed: 1'b0,
            alu_op: ALU_ADD, dm_we: 1'b0, wb_from_mem: 1'b0,
            is_branch: 1'b0, unknown: 1'b0};
    unique case (opc)
      OPC_REG: begin
        ctl.dst_is_rd = 1'b1;
        if (fn == FN_ADD) begin
          ctl.rf_we  = 1'b1;
          ctl.alu_op = ALU_ADD;
        end else if (fn == FN_SUB) begin
          ctl.rf_we  = 1'b1;
          ctl.alu_op = ALU_SUB;
        end else begin
          ctl.unknown = 1'b1;
        end
      end
      OPC_ORI: begin
        ctl.rf_we    = 1'b1;
        ctl.b_is_imm = 1'b1;
        ctl.alu_op   = ALU_OR;
      end
      OPC_LOAD: begin
        ctl.rf_we       = 1'b1;
        ctl.b_is_imm    = 1'b1;
        ctl.imm_signed  = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      OPC_STOR: begin
        ctl.b_is_imm   = 1'b1;
        ctl.imm_signed = 1'b1;
        ctl.dm_we      = 1'b1;
      end
      OPC_BEQ: begin
        ctl.imm_signed = 1'b1;
        ctl.alu_op     = ALU_SUB;
        ctl.is_branch  = 1'b1;
      end
      default: ctl.unknown = 1'b1;
    endcase
  end

  // R5/R7: branches and unknown encodings never write state
  always_comb begin
    a_r7_unknown_quiet: assert (!(ctl.unknown && (ctl.rf_we || ctl.dm_we)));
    a_r5_branch_quiet:  assert (!(ctl.is_branch && (ctl.rf_we || ctl.dm_we)));
  end

endmodule

// File: rtl/cpu_wordmem.sv
module cpu_wordmem #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_we,
  input  logic [IAW-1:0]   prog_idx,
  input  logic [31:0]      prog_word,
  input  logic [4:0]       peek_sel,
  output logic [31:0]      peek_val
);

  logic [XLEN-1:0] pc_q, pc_d, pc_inc, pc_br;
  logic [XLEN-1:0] ins;
  ctl_t            ctl;
  logic [RSEL-1:0] f_rs, f_rt, f_rd, wr_sel;
  logic [15:0]     f_imm;
  logic [XLEN-1:0] imm_ext, bus_a, bus_b, opnd_b, alu_y, dm_q, wb_val;
  logic            alu_z, take;

  cpu_wordmem #(.W(XLEN), .WORDS(IMEM_WORDS)) u_imem (
    .clk(clk), .we(prog_we), .waddr(prog_idx), .wdata(prog_word),
    .raddr(pc_q[IAW+1:2]), .rdata(ins));

  assign f_rs  = ins[25:21];
  assign f_rt  = ins[20:16];
  assign f_rd  = ins[15:11];
  assign f_imm = ins[15:0];

  cpu_ctrl u_ctrl (.opc(ins[31:26]), .fn(ins[5:0]), .ctl(ctl));

  assign imm_ext = ctl.imm_signed ? {{(XLEN-16){f_imm[15]}}, f_imm}
                                  : {{(XLEN-16){1'b0}}, f_imm};
  assign wr_sel  = ctl.dst_is_rd ? f_rd : f_rt;

  cpu_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(ctl.rf_we), .waddr(wr_sel), .wdata(wb_val),
    .ra(f_rs), .rb(f_rt), .rc(peek_sel),
    .qa(bus_a), .qb(bus_b), .qc(peek_val));

  assign opnd_b = ctl.b_is_imm ? imm_ext : bus_b;

  cpu_alu #(.W(XLEN)) u_alu (.a(bus_a), .b(opnd_b), .op(ctl.alu_op),
    .y(alu_y), .zero(alu_z));

  cpu_wordmem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk(clk), .we(ctl.dm_we), .waddr(alu_y[DAW+1:2]), .wdata(bus_b),
    .raddr(alu_y[DAW+1:2]), .rdata(dm_q));

  assign wb_val = ctl.wb_from_mem ? dm_q : alu_y;

  // next-state
  assign pc_inc = pc_q + XLEN'(4);
  assign pc_br  = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
  assign take   = ctl.is_branch && alu_z;

  always_comb begin
    pc_d = pc_inc;
    if (take) pc_d = pc_br;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R1: first fetch after reset release is word 0
  a_r1_pc_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !$past(rst_n)) |-> (pc_q == '0));

  // R7: non-branch instructions step the PC by one word
  a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.is_branch |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R5: untaken branch falls through, taken branch lands on the target
  a_r5_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.is_branch && bus_a == bus_b) |=>
      (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}));
  a_r5_branch_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.is_branch && bus_a != bus_b) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R4: a store leaves the register file untouched
  a_r4_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.dm_we |-> !ctl.rf_we);

endmodule

// File: tb/sim_cpu_core.sv
`timescale 1ns/1ps
module sim_cpu_core;

  localparam int IAW = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           prog_we;
  logic [IAW-1:0] prog_idx;
  logic [31:0]    prog_word;
  logic [4:0]     peek_sel;
  logic [31:0]    peek_val;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cpu_core u0 (.clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_idx(prog_idx),
    .prog_word(prog_word), .peek_sel(peek_sel), .peek_val(peek_val));

  function automatic logic [31:0] e_r(input int rs, rt, rd, fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] e_i(input int op, rs, rt, imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // {requirement number, register, expected value}
  localparam logic [40:0] EXPECT [17] = '{
    {4'd6, 5'd0,  32'h0000_0000},  // R6 write to r0 dropped
    {4'd3, 5'd1,  32'h0000_1234},  // R3
    {4'd3, 5'd2,  32'h0000_FFFF},  // R3 zero extension
    {4'd2, 5'd3,  32'h0001_1233},  // R2 add
    {4'd2, 5'd4,  32'hFFFF_1235},  // R2 subtract wraps
    {4'd3, 5'd5,  32'h0000_0010},  // R3
    {4'd4, 5'd6,  32'h0001_1233},  // R4 negative offset load
    {4'd6, 5'd7,  32'h0000_1234},  // R6 r0 reads zero as source
    {4'd7, 5'd8,  32'h0000_0000},  // R7 unknown opcode
    {4'd5, 5'd9,  32'h0000_0001},  // R5 not-taken falls through
    {4'd5, 5'd10, 32'h0000_0000},  // R5 taken skips
    {4'd5, 5'd11, 32'h0000_0002},  // R5 target executed
    {4'd9, 5'd12, 32'h0000_0000},  // R9 loop counter
    {4'd9, 5'd13, 32'h0000_0003},  // R9 back-to-back use
    {4'd9, 5'd14, 32'h0000_0001},  // R9
    {4'd4, 5'd15, 32'h0000_0003},  // R4 store then load
    {4'd7, 5'd16, 32'h0000_0000}   // R7 unknown function code
  };

  task automatic put(input int idx, input logic [31:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_idx = IAW'(idx); prog_word = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic chk(input int req, input int r, input logic [31:0] exp);
    peek_sel = 5'(r);
    #0.5;
    total++;
    if (peek_val !== exp) begin
      bad++;
      $display("FAIL R%0d reg %0d: actual=%h expected=%h", req, r, peek_val, exp);
    end
  endtask

  task automatic walk_table();
    for (int i = 0; i < 17; i++)
      chk(int'(EXPECT[i][40:37]), int'(EXPECT[i][36:32]), EXPECT[i][31:0]);
  endtask

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_idx = '0; prog_word = '0; peek_sel = '0;
    put(0,  e_i(6'h0D, 0, 1, 16'h1234));
    put(1,  e_i(6'h0D, 0, 2, 16'hFFFF));
    put(2,  e_r(1, 2, 3, 6'h21));
    put(3,  e_r(1, 2, 4, 6'h23));
    put(4,  e_i(6'h2B, 0, 3, 8));
    put(5,  e_i(6'h0D, 0, 5, 16));
    put(6,  e_i(6'h23, 5, 6, 16'hFFF8));
    put(7,  e_i(6'h0D, 0, 0, 16'h0055));
    put(8,  e_r(0, 1, 7, 6'h21));
    put(9,  e_i(6'h3F, 0, 8, 16'h0077));
    put(10, e_i(6'h04, 1, 2, 1));
    put(11, e_i(6'h0D, 0, 9, 1));
    put(12, e_i(6'h04, 1, 7, 1));
    put(13, e_i(6'h0D, 0, 10, 16'h0BAD));
    put(14, e_i(6'h0D, 0, 11, 2));
    put(15, e_i(6'h0D, 0, 12, 3));
    put(16, e_i(6'h0D, 0, 14, 1));
    put(17, e_r(12, 14, 12, 6'h23));
    put(18, e_r(13, 14, 13, 6'h21));
    put(19, e_i(6'h04, 12, 0, 1));
    put(20, e_i(6'h04, 0, 0, 16'hFFFC));
    put(21, e_i(6'h2B, 5, 13, 4));
    put(22, e_i(6'h23, 0, 15, 20));
    put(23, e_r(1, 1, 16, 6'h20));
    put(24, e_i(6'h04, 0, 0, 16'hFFFF));

    // R1: registers read zero while in reset
    for (int r = 1; r < 17; r++) chk(1, r, 32'h0);

    @(negedge clk); rst_n = 1'b1;
    repeat (120) @(negedge clk);
    walk_table();
    // R8: port follows selection without a clock
    chk(8, 3, 32'h0001_1233);
    chk(8, 4, 32'hFFFF_1235);

    // R1: asynchronous reset mid-run clears registers, then rerun from word 0
    #1 rst_n = 1'b0;
    chk(1, 3, 32'h0);
    chk(1, 13, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // R9: after one edge only word 0 has executed
    @(negedge clk);
    chk(1, 1, 32'h0000_1234);
    chk(9, 2, 32'h0);
    repeat (120) @(negedge clk);
    walk_table();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule